// File: doc/BRIEF.md
# Universal Bus Register

An 18-lane data register whose storage can act as a wire, a level-sensitive latch or a rising-edge flip-flop. A single mode input picks the behaviour. While `le` is high the register is transparent, so each output lane follows its input lane with no clock involved. While `le` is low the register behaves as an edge-triggered register clocked by `clk`. Between rising edges of `clk` it keeps its last value.

An active-low enable, `oe_n`, controls only the output drivers. When the drivers are off, the shared bus pins are released to high impedance and the storage keeps working. The driven value is also exported as a plain vector, `q_data`, together with an active-high flag, `drv_en`. Targets without internal tri-states can use these two signals instead of the bus, and a bench can read the state without resolving `z`.

The block has no reset, and its state at power-up is undefined. It has no streaming handshake: every pin is a plain control or data level, so back-pressure does not apply. `clk` is used only as an edge source while `le` is low.

Top module: `universal_bus_reg`

## Requirements
- R1: While `le` is 1, `q_data` equals `din` lane for lane. This holds whatever the level of `clk` and however `din` changes.
- R2: While `le` is 0, a 0-to-1 transition of `clk` copies `din` into `q_data`.
- R3: While `le` is 0 and `clk` makes no rising transition, `q_data` keeps its value. Changes on `din` and falling `clk` edges have no effect on it.
- R4: With `oe_n` = 1, `drv_en` is 0 and `q_bus` is released. With `oe_n` = 0, `drv_en` is 1 and `q_bus` carries `q_data`.
- R5: When `le` falls while `clk` is 1, `q_data` keeps the value `din` had at that moment.
- R6: When `le` falls while `clk` is 0, `q_data` keeps the value `din` had at that moment until the next rising `clk` edge. That edge then loads the current `din`.
- R7: `oe_n` has no effect on storage. Loads and transparency continue while the drivers are off.
- R8: A rising `clk` edge taken while `le` is 1 leaves no trace. Once `le` falls, the stored value is the `din` present at the fall.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | 18 | Data lanes in |
| le | input | 1 | Mode select: 1 transparent, 0 edge-clocked |
| clk | input | 1 | Capture clock, rising edge active while `le` is 0 |
| oe_n | input | 1 | Active-low output driver enable |
| q_bus | output | 18 | Three-state data lanes out |
| q_data | output | 18 | Value currently held or passed, always driven |
| drv_en | output | 1 | Active-high copy of the driver enable |

## Verification
The assertions assume that `din` and `le` never change at the same instant as a rising `clk` edge. They also assume that `le` and `din` do not change together at a falling `le` edge. This matches the setup and hold discipline of a real register. The bench respects this by moving every input in its own time step, a few time units away from any `clk` transition. It also lets each change settle before it samples the outputs. Both directions of `le` falling are exercised on purpose, once with `clk` high and once with `clk` low. The bus lanes are compared only when the drivers are on. When they are off, the released state is observed through `drv_en`.

// File: rtl/ubr_pkg.sv
package ubr_pkg;

  parameter int unsigned UBR_LANES = 18;

  typedef enum logic {
    STORE_CLOCKED = 1'b0,
    STORE_PASS    = 1'b1
  } store_mode_e;

  function automatic store_mode_e mode_of(input logic le_lvl);
    return le_lvl ? STORE_PASS : STORE_CLOCKED;
  endfunction

endpackage

// File: rtl/ubr_lane.sv
// One storage lane: master and slave latches. Forcing both open gives pass-through;
// releasing the force leaves a plain rising-edge register.
module ubr_lane (
  input  logic d,
  input  logic open_c,
  input  logic clk,
  output logic q
);
  logic mst;
  logic slv;

  // master is open while the clock is low, or whenever pass-through is forced
  always_latch begin
    if (open_c || !clk) mst <= d;
  end

  // slave is open while the clock is high, or whenever pass-through is forced
  always_latch begin
    if (open_c || clk) slv <= mst;
  end

  assign q = slv;
endmodule

// File: rtl/ubr_store.sv
module ubr_store #(
  parameter int unsigned WIDTH = ubr_pkg::UBR_LANES
) (
  input  logic [WIDTH-1:0] d,
  input  logic             le,
  input  logic             clk,
  output logic [WIDTH-1:0] q
);
  import ubr_pkg::*;

  store_mode_e mode;
  logic        open_c;

  assign mode   = mode_of(le);
  assign open_c = (mode == STORE_PASS);

  for (genvar g = 0; g < WIDTH; g++) begin : g_lane
    ubr_lane u_lane (
      .d      (d[g]),
      .open_c (open_c),
      .clk    (clk),
      .q      (q[g])
    );
  end

  // ---------------- embedded checks ----------------
  logic [WIDTH-1:0] d_at_rise = '0;
  logic             clean     = 1'b0;
  logic [WIDTH-1:0] d_at_fall = '0;
  logic             fell_high = 1'b0;
  logic             pend_low  = 1'b0;

  // clean: the last rising clk edge came with le low, and le has not risen since
  always @(posedge clk or posedge le) begin
    if (le) clean <= 1'b0;
    else begin
      clean     <= 1'b1;
      d_at_rise <= d;
    end
  end

  always @(negedge le) begin
    d_at_fall <= d;
    fell_high <= clk;
  end

  // pend_low: le closed during a low clk phase and no rising edge has come yet
  always @(negedge le or posedge clk) begin
    if (!le && !clk) pend_low <= 1'b1;
    else             pend_low <= 1'b0;
  end

  always @(negedge clk) begin
    if (le) begin
      AST_PASS_THROUGH: assert (q == d) else $error("pass-through broken"); // R1
    end
    if (clean && !le) begin
      AST_EDGE_LOAD: assert (q == d_at_rise) else $error("edge load lost"); // R2
    end
    if (!le && !clean && fell_high) begin
      AST_CLOSE_HIGH: assert (q == d_at_fall) else $error("close with clk high lost value"); // R5
    end
  end

  always @(d) begin
    if (pend_low && !le) begin
      AST_CLOSE_LOW_HOLD: assert (q == d_at_fall) else $error("held value moved before edge"); // R6
    end
  end

endmodule

// File: rtl/ubr_drive.sv
module ubr_drive #(
  parameter int unsigned WIDTH = ubr_pkg::UBR_LANES
) (
  input  logic [WIDTH-1:0] q,
  input  logic             oe_n,
  output wire  [WIDTH-1:0] bus,
  output logic             en
);
  assign en  = ~oe_n;
  assign bus = en ? q : {WIDTH{1'bz}};
endmodule

// File: rtl/universal_bus_reg.sv
module universal_bus_reg #(
  parameter int unsigned WIDTH = ubr_pkg::UBR_LANES
) (
  input  logic [WIDTH-1:0] din,
  input  logic             le,
  input  logic             clk,
  input  logic             oe_n,
  output wire  [WIDTH-1:0] q_bus,
  output logic [WIDTH-1:0] q_data,
  output logic             drv_en
);
  logic [WIDTH-1:0] stored;

  ubr_store #(.WIDTH(WIDTH)) u_store (
    .d   (din),
    .le  (le),
    .clk (clk),
    .q   (stored)
  );

  ubr_drive #(.WIDTH(WIDTH)) u_drive (
    .q    (stored),
    .oe_n (oe_n),
    .bus  (q_bus),
    .en   (drv_en)
  );

  assign q_data = stored;
endmodule

// File: tb/tb_universal_bus_reg.sv
`timescale 1ns/1ps
module tb_universal_bus_reg;
  localparam int W          = 18;
  localparam int CLK_PERIOD = 10;
  localparam int STEP       = CLK_PERIOD / 4;

  logic [W-1:0] din = '0;
  logic         le  = 1'b1;
  logic         clk = 1'b0;
  logic         oe_n = 1'b1;
  wire  [W-1:0] q_bus;
  logic [W-1:0] q_data;
  logic         drv_en;

  universal_bus_reg #(.WIDTH(W)) dut (
    .din(din), .le(le), .clk(clk), .oe_n(oe_n),
    .q_bus(q_bus), .q_data(q_data), .drv_en(drv_en)
  );

  typedef struct {
    string        tag;
    logic [W-1:0] data;
    logic         en;
  } item_t;

  item_t        exp_q[$];
  event         chk_ev;
  int           total = 0;
  int           bad   = 0;
  logic [W-1:0] held_m = '0;

  // ---- driver side: stimulus plus reference model ----
  task automatic put_din(input logic [W-1:0] v);
    din = v; #STEP;
  endtask

  task automatic clk_up();
    clk = 1'b1;
    if (!le) held_m = din;
    #STEP;
  endtask

  task automatic clk_dn();
    clk = 1'b0; #STEP;
  endtask

  task automatic set_le(input logic v);
    if (le && !v) held_m = din;
    le = v; #STEP;
  endtask

  task automatic set_oe_n(input logic v);
    oe_n = v; #STEP;
  endtask

  task automatic expect_now(input string tag);
    item_t it;
    it.tag  = tag;
    it.data = le ? din : held_m;
    it.en   = ~oe_n;
    exp_q.push_back(it);
    -> chk_ev;
    #3;
  endtask

  // ---- monitor side ----
  initial begin
    forever begin
      @(chk_ev);
      #1;
      while (exp_q.size() > 0) begin
        item_t it;
        it = exp_q.pop_front();
        total++;
        if (q_data !== it.data) begin
          bad++;
          $display("FAIL %s q_data actual=%h expected=%h", it.tag, q_data, it.data);
        end
        total++;
        if (drv_en !== it.en) begin
          bad++;
          $display("FAIL %s drv_en actual=%b expected=%b", it.tag, drv_en, it.en);
        end
        if (it.en) begin
          total++;
          if (q_bus !== it.data) begin
            bad++;
            $display("FAIL %s q_bus actual=%h expected=%h", it.tag, q_bus, it.data);
          end
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    #STEP;
    expect_now("R4 power-up disabled");

    // R1 transparency at both clock levels
    put_din(18'h3FFFF); expect_now("R1 clk low");
    clk_up();           expect_now("R1 clk rise");
    put_din(18'h12345); expect_now("R1 clk high");
    clk_dn();
    put_din(18'h2AAAA); expect_now("R1 after fall");

    // R8 edge while transparent, then R5 close with clk high
    clk_up();
    put_din(18'h15555);
    set_le(1'b0);       expect_now("R5 close high");
    put_din(18'h00F0F); expect_now("R3 din ignored");
    clk_dn();           expect_now("R3 falling clk ignored");

    // R2 clocked load
    put_din(18'h3C3C3);
    clk_up();           expect_now("R2 edge load");
    put_din(18'h00001); expect_now("R3 hold after edge");
    clk_dn();           expect_now("R3 hold clk low");

    // R6 close with clk low
    set_le(1'b1);
    put_din(18'h0A5A5);
    set_le(1'b0);       expect_now("R6 close low");
    put_din(18'h30303); expect_now("R6 hold until edge");
    clk_up();           expect_now("R6 next edge loads");

    // R4 enable, R7 storage runs while disabled
    set_oe_n(1'b0);     expect_now("R4 drivers on");
    set_oe_n(1'b1);
    clk_dn();
    put_din(18'h11111);
    clk_up();           expect_now("R7 load while off");
    set_le(1'b1);
    put_din(18'h22222); expect_now("R7 pass while off");
    set_oe_n(1'b0);     expect_now("R4 bus follows");

    // R8 edge while transparent, close with clk low
    clk_dn();
    put_din(18'h0BEEF);
    clk_up();
    put_din(18'h1CAFE);
    clk_dn();
    put_din(18'h2D00D);
    set_le(1'b0);       expect_now("R8 edge leaves no trace");
    clk_up();
    clk_dn();           expect_now("R2 load after R8 case");

    // R2 varied patterns
    seed = 32'h1234_5678;
    for (int i = 0; i < 10; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      put_din(seed[W+5:6]);
      clk_up();
      expect_now("R2 pattern");
      clk_dn();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule